// File: doc/BRIEF.md
# Suspend and Resume Clock Controller

This block runs the chip-wide low-power sequence. It has three states: normal, suspend and resume. In normal, firmware asks for suspend by writing a request bit. The block then drops the oscillator enable and masks the internal clock enable. While suspended, nothing is clocked. An asynchronous latch watches two wake sources: activity on the USB bus, and a change on any key input compared with the key values captured at suspend entry. Each source has its own enable bit.

When an enabled wake event is caught, the block re-enables the oscillator but keeps the internal clocks masked. This resume interval lasts a programmed number of milliseconds. The block then returns to normal without any firmware action.

The block also counts continuous USB bus idle time on a free-running millisecond tick. When the idle time reaches the threshold, it raises a sticky interrupt. It does not suspend on its own when this happens. Firmware clears the interrupt with a write-one-to-clear strobe.

Top module: `susp_ctl`

## Requirements
- R1: After reset the state is normal (pwr_state 0), osc_en and clk_en are 1, idle_irq is 0, both wake enables are off and the resume code is 0.
- R2: A susp_wr pulse accepted in normal moves the state to suspend (pwr_state 1) on the second rising edge after the pulse. osc_en and clk_en are then 0. The request clears itself on entry, so after a later wake the block stays in normal.
- R3: A susp_wr pulse given while in suspend or resume is ignored and causes no suspend after the return to normal.
- R4: While in normal, idle_irq rises after IDLE_MS consecutive tick_1ms pulses with usb_idle held high. A low usb_idle restarts the count. Reaching the threshold does not change the state.
- R5: idle_irq stays set until an irq_clr pulse clears it. A new idle threshold in the same cycle as irq_clr wins.
- R6: usb_act wakes the block from suspend only when cfg_wdata bit 4 was written as 1 through cfg_we.
- R7: Any key differing from its value at suspend entry wakes the block only when cfg_wdata bit 5 was written as 1.
- R8: An enabled wake event seen before rising edge A puts the state into resume (pwr_state 2) at edge A+2. In resume, osc_en is 1 and clk_en is 0.
- R9: The resume length in ticks is derived from the 4-bit code in cfg_wdata[3:0]. Code 0 gives 1. Codes 1 to 9 give twice the code. Codes 10 to 15 are clamped to 20.
- R10: Resume ends on the tick that completes the programmed length. The state then becomes normal at that edge with no firmware action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock from the oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse per millisecond from the slow time base |
| susp_wr | input | 1 | Firmware write of the suspend request bit |
| cfg_we | input | 1 | Write strobe for the wake configuration |
| cfg_wdata | input | 6 | Bit 5 key wake enable, bit 4 USB wake enable, bits 3:0 resume code |
| irq_clr | input | 1 | Write-one-to-clear strobe for the idle interrupt |
| usb_idle | input | 1 | USB bus idle detector level |
| usb_act | input | 1 | USB bus activity indication |
| keys | input | KEY_W | Key input levels |
| osc_en | output | 1 | Oscillator enable |
| clk_en | output | 1 | Internal clock gate enable |
| idle_irq | output | 1 | Sticky USB idle interrupt |
| pwr_state | output | 2 | Current state: 0 normal, 1 suspend, 2 resume |

## Verification
Any fault in the state register, the wake synchroniser or the resume counter shows on pwr_state, osc_en and clk_en within a cycle. A stuck wake latch or a lost request shows as a wake that comes early or never comes. A wrong resume counter shows as a return to normal that is off by whole ticks. An idle counter that fails to restart, or an interrupt that is not sticky, shows on idle_irq at the first tick where it differs. The reference model compares all four outputs on every cycle. A divergence is therefore reported in the cycle it first appears, not at the end of a phase.

// File: rtl/susp_ctl.sv
module susp_ctl #(
  parameter int KEY_W   = 8,
  parameter int IDLE_MS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1ms,
  input  logic             susp_wr,
  input  logic             cfg_we,
  input  logic [5:0]       cfg_wdata,
  input  logic             irq_clr,
  input  logic             usb_idle,
  input  logic             usb_act,
  input  logic [KEY_W-1:0] keys,
  output logic             osc_en,
  output logic             clk_en,
  output logic             idle_irq,
  output logic [1:0]       pwr_state
);

  localparam int IW = $clog2(IDLE_MS + 1);

  typedef enum logic [1:0] {NORM = 2'd0, SUSP = 2'd1, RES = 2'd2} st_t;

  st_t              state;
  logic             sreq;
  logic             usb_wen, key_wen;
  logic [3:0]       rcode;
  logic [KEY_W-1:0] key_ref;
  logic             wake_lat, wsync1, wsync2;
  logic [4:0]       rcnt, rlen;
  logic [IW-1:0]    icnt;
  logic             idle_hit;

  wire in_susp  = (state == SUSP);
  wire wake_evt = in_susp & ((usb_wen & usb_act) | (key_wen & (keys != key_ref)));

  assign osc_en    = (state != SUSP);
  assign clk_en    = (state == NORM);
  assign pwr_state = state;

  always_comb begin
    if (rcode == 4'd0)       rlen = 5'd1;
    else if (rcode >= 4'd10) rlen = 5'd20;
    else                     rlen = {rcode, 1'b0};
  end

  assign idle_hit = (state == NORM) && usb_idle && tick_1ms &&
                    (icnt == IW'(IDLE_MS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usb_wen <= 1'b0;
      key_wen <= 1'b0;
      rcode   <= 4'd0;
    end else if (cfg_we) begin
      key_wen <= cfg_wdata[5];
      usb_wen <= cfg_wdata[4];
      rcode   <= cfg_wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       key_ref <= '0;
    else if (!in_susp) key_ref <= keys;
  end

  always_ff @(posedge clk or negedge rst_n or posedge wake_evt) begin
    if (!rst_n)        wake_lat <= 1'b0;
    else if (wake_evt) wake_lat <= 1'b1;
    else if (!in_susp) wake_lat <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsync1 <= 1'b0;
      wsync2 <= 1'b0;
    end else if (!in_susp) begin
      wsync1 <= 1'b0;
      wsync2 <= 1'b0;
    end else begin
      wsync1 <= wake_lat;
      wsync2 <= wsync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= NORM;
      sreq  <= 1'b0;
      rcnt  <= '0;
    end else begin
      case (state)
        NORM: begin
          rcnt <= '0;
          if (sreq) begin
            state <= SUSP;
            sreq  <= 1'b0;
          end else if (susp_wr) begin
            sreq <= 1'b1;
          end
        end
        SUSP: begin
          rcnt <= '0;
          if (wsync2) state <= RES;
        end
        RES: begin
          if (tick_1ms) begin
            if (rcnt == rlen - 5'd1) begin
              state <= NORM;
              rcnt  <= '0;
            end else begin
              rcnt <= rcnt + 5'd1;
            end
          end
        end
        default: state <= NORM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt     <= '0;
      idle_irq <= 1'b0;
    end else begin
      if (state != NORM || !usb_idle)                 icnt <= '0;
      else if (tick_1ms && icnt != IW'(IDLE_MS))      icnt <= icnt + 1'b1;
      if (idle_hit)     idle_irq <= 1'b1;
      else if (irq_clr) idle_irq <= 1'b0;
    end
  end

  // R2
  susp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SUSP && $past(state) == NORM) |-> $past(sreq));

  // R8
  wake_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RES && $past(state) == SUSP) |-> $past(wsync2));

  // R10
  res_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == NORM && $past(state) == RES) |-> $past(tick_1ms));

  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_irq) |-> ($past(usb_idle) && $past(tick_1ms)));

  // R9
  res_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RES) |-> (rcnt < 5'd20));

  // R1
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd3);

endmodule

// File: tb/tb_susp_ctl.sv
module tb_susp_ctl;
  localparam int KW = 8;
  localparam int IDLE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1ms = 1'b0;
  logic susp_wr = 1'b0, cfg_we = 1'b0, irq_clr = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic usb_idle = 1'b0, usb_act = 1'b0;
  logic [KW-1:0] keys = 8'h5A;
  logic osc_en, clk_en, idle_irq;
  logic [1:0] pwr_state;

  susp_ctl #(.KEY_W(KW), .IDLE_MS(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .susp_wr(susp_wr),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .irq_clr(irq_clr),
    .usb_idle(usb_idle), .usb_act(usb_act), .keys(keys),
    .osc_en(osc_en), .clk_en(clk_en), .idle_irq(idle_irq), .pwr_state(pwr_state));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, tdiv = 0;
  bit chk_on = 0;
  string cur_req = "R1";

  int m_st, m_wdly, m_rcnt, m_icnt, m_code;
  bit m_sreq, m_irq, m_uen, m_ken;
  logic [KW-1:0] m_kref;

  function automatic int res_len(int c);
    if (c == 0) return 1;
    if (c >= 10) return 20;
    return 2 * c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_wdly = 0; m_rcnt = 0; m_icnt = 0; m_code = 0;
      m_sreq = 0; m_irq = 0; m_uen = 0; m_ken = 0; m_kref = '0;
    end else begin
      int st, nst;
      bit ev, hit;
      st = m_st; nst = st;
      ev = (st == 1) && ((m_uen && usb_act) || (m_ken && keys != m_kref));
      hit = (st == 0) && usb_idle && tick_1ms && (m_icnt == IDLE - 1);
      if (st == 0) begin
        m_rcnt = 0;
        if (m_sreq) begin nst = 1; m_sreq = 0; end
        else if (susp_wr) m_sreq = 1;
      end else if (st == 1) begin
        m_rcnt = 0;
        if (m_wdly > 0) begin
          m_wdly++;
          if (m_wdly == 3) begin nst = 2; m_wdly = 0; end
        end else if (ev) m_wdly = 1;
      end else begin
        if (tick_1ms) begin
          if (m_rcnt == res_len(m_code) - 1) begin nst = 0; m_rcnt = 0; end
          else m_rcnt++;
        end
      end
      if (st != 1) m_wdly = 0;
      if (st != 0 || !usb_idle) m_icnt = 0;
      else if (tick_1ms && m_icnt != IDLE) m_icnt++;
      if (hit) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      if (st != 1) m_kref = keys;
      if (cfg_we) begin
        m_ken = cfg_wdata[5]; m_uen = cfg_wdata[4]; m_code = int'(cfg_wdata[3:0]);
      end
      m_st = nst;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick_1ms = (tdiv == 0);
    if (chk_on) begin
      chk(cur_req, "pwr_state", int'(pwr_state), m_st);
      chk(cur_req, "osc_en", int'(osc_en), (m_st != 1) ? 1 : 0);
      chk(cur_req, "clk_en", int'(clk_en), (m_st == 0) ? 1 : 0);
      chk(cur_req, "idle_irq", int'(idle_irq), int'(m_irq));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 30000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=30000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    chk_on = 0;
    rst_n = 0;
    wait_n(2);
    rst_n = 1;
    wait_n(1);
    chk_on = 1;
  endtask

  task automatic pulse_susp();
    susp_wr = 1; wait_n(1); susp_wr = 0;
  endtask

  task automatic write_cfg(logic [5:0] v);
    cfg_wdata = v; cfg_we = 1; wait_n(1); cfg_we = 0;
  endtask

  task automatic wake_usb();
    usb_act = 1; wait_n(1); usb_act = 0;
  endtask

  initial begin
    wait_n(1);
    do_reset();
    cur_req = "R1";
    chk("R1", "reset state", int'(pwr_state), 0);
    chk("R1", "reset osc_en", int'(osc_en), 1);
    chk("R1", "reset clk_en", int'(clk_en), 1);
    chk("R1", "reset irq", int'(idle_irq), 0);

    cur_req = "R4";
    usb_idle = 1; wait_n(14); usb_idle = 0; wait_n(2);
    usb_idle = 1; wait_n(14);
    chk("R4", "irq after broken idle", int'(idle_irq), 0);
    wait_n(20);
    chk("R4", "irq after full idle", int'(idle_irq), 1);
    chk("R4", "no self suspend", int'(pwr_state), 0);
    usb_idle = 0;

    cur_req = "R5";
    wait_n(10);
    chk("R5", "irq sticky", int'(idle_irq), 1);
    irq_clr = 1; wait_n(1); irq_clr = 0; wait_n(1);
    chk("R5", "irq cleared", int'(idle_irq), 0);

    cur_req = "R2";
    write_cfg(6'h00);
    pulse_susp(); wait_n(2);
    chk("R2", "suspend state", int'(pwr_state), 1);
    chk("R2", "osc off", int'(osc_en), 0);
    chk("R2", "clk masked", int'(clk_en), 0);

    cur_req = "R6";
    wake_usb(); wait_n(10);
    chk("R6", "usb wake disabled", int'(pwr_state), 1);
    cur_req = "R7";
    keys = 8'h5B; wait_n(10);
    chk("R7", "key wake disabled", int'(pwr_state), 1);
    keys = 8'h5A;

    do_reset();
    cur_req = "R8";
    write_cfg(6'h13);
    pulse_susp(); wait_n(3);
    wake_usb(); wait_n(2);
    chk("R8", "resume state", int'(pwr_state), 2);
    chk("R8", "osc on", int'(osc_en), 1);
    chk("R8", "clk masked", int'(clk_en), 0);
    cur_req = "R10";
    wait_n(30);
    chk("R10", "auto normal 6 ticks", int'(pwr_state), 0);
    cur_req = "R2";
    wait_n(12);
    chk("R2", "request self-cleared", int'(pwr_state), 0);

    cur_req = "R7";
    write_cfg(6'h20);
    pulse_susp(); wait_n(3);
    wake_usb(); wait_n(6);
    chk("R7", "usb ignored key-only", int'(pwr_state), 1);
    keys = 8'hA5; wait_n(1); keys = 8'h5A; wait_n(2);
    chk("R7", "key wake", int'(pwr_state), 2);
    cur_req = "R9";
    wait_n(5);
    chk("R9", "code0 clamp to 1", int'(pwr_state), 0);

    cur_req = "R3";
    write_cfg(6'h3C);
    pulse_susp(); wait_n(3);
    pulse_susp(); wait_n(2);
    wake_usb(); wait_n(2);
    chk("R3", "resume after ignored write", int'(pwr_state), 2);
    cur_req = "R9";
    pulse_susp();
    wait_n(70);
    chk("R9", "still resume at 17 ticks", int'(pwr_state), 2);
    wait_n(14);
    chk("R9", "code12 clamp to 20", int'(pwr_state), 0);
    cur_req = "R3";
    wait_n(15);
    chk("R3", "no late suspend", int'(pwr_state), 0);

    cur_req = "R5";
    usb_idle = 1; wait_n(30);
    chk("R5", "irq set again", int'(idle_irq), 1);
    usb_idle = 0;
    wait_n(4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule